// File: doc/BRIEF.md
# DMA Bus Master Cycle Engine

This block lets a network controller's local DMA channel act as master on a shared bus. The bus is 16 bits wide and multiplexes address and data. A burst begins with a one-cycle start pulse, which carries a direction, a transfer width, a start address and a transfer count. The engine then raises a bus request and waits for a grant. Once it holds the bus it runs one memory cycle per transfer. Each cycle has four phases clocked by the bus clock: an address phase, two strobe phases, and a closing phase. A high ready input stretches the cycle with wait states.

In word mode all sixteen lines carry data after the address phase. In byte mode the upper eight lines keep carrying the upper address byte and only the lower eight lines carry data. After each transfer the address pointer moves on by the transfer width. When the last transfer ends, the request is dropped and every bus output returns to high impedance.

If the grant is withdrawn mid-burst, the cycle in flight runs to its end. The engine then releases the bus but keeps requesting, and resumes at the next address when the grant returns. Tri-state control appears as explicit enables: one for the strobe pair and one for each half of the address/data lines.

Top module: `bm_cycle_engine`

## Requirements
- R1: An accepted start raises `breq_o` on the next clock. The request stays high until the closing phase of the last transfer, then drops.
- R2: While the engine does not own the bus (idle, or requesting before a grant), `strobe_oe_o` is low and `ad_oe_o` is 0. In `ad_oe_o`, bit 0 enables lines 7:0 and bit 1 enables lines 15:8. The first address phase of a tenure follows a clock with the grant high.
- R3: During the address phase (t1), `ads_o` is high, all 16 lines drive the transfer address (`ad_oe_o` = 2'b11), and both strobes are high.
- R4: With ready low, the selected strobe is low for exactly two clocks (t2, t3). Then comes one closing clock (t4), marked by `xfer_done_o`, with both strobes high. That is four clocks per transfer.
- R5: Ready is sampled at the end of t3 and of every wait state. Each clock it is high adds one wait state with the strobe held low.
- R6: On writes, `mwr_n_o` is low in t2, t3 and wait states, and `mrd_n_o` stays high. In word mode the write data drives all 16 lines from t2 through t4.
- R7: On reads, `mrd_n_o` is low in t2, t3 and wait states, and `mwr_n_o` stays high. In word mode the lines are released after t1. The value on `ad_i` at the strobe's rising edge appears on `rdata_o` during t4: all 16 bits in word mode, and the low byte zero-extended in byte mode.
- R8: In byte mode the upper 8 lines keep driving address bits 15:8 from t2 through t4. The lower 8 lines carry the data byte on writes and are released on reads.
- R9: The address increases by 2 per transfer in word mode and by 1 in byte mode, wrapping at 16 bits.
- R10: A burst runs exactly the programmed number of transfers. A start with a count of zero is ignored.
- R11: If the grant falls during a cycle, that cycle completes. The clock after its t4 has all bus enables low while `breq_o` stays high. No new t1 occurs until the grant returns, and the burst then resumes at the next address.
- R12: A start pulse that arrives while a burst is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle burst start |
| write_i | input | 1 | Burst direction, 1 = write to memory |
| byte_mode_i | input | 1 | 1 = byte transfers, 0 = word transfers |
| start_addr_i | input | 16 | First transfer address |
| xfer_cnt_i | input | 8 | Number of transfers in the burst |
| wdata_i | input | 16 | Write data, sampled during t1 |
| breq_o | output | 1 | Bus request |
| bgnt_i | input | 1 | Bus grant |
| ready_i | input | 1 | High requests wait states |
| ads_o | output | 1 | Address strobe, high during t1 |
| mwr_n_o | output | 1 | Memory write strobe, active low |
| mrd_n_o | output | 1 | Memory read strobe, active low |
| strobe_oe_o | output | 1 | Drive enable for both strobes |
| ad_o | output | 16 | Address/data lines, driven value |
| ad_oe_o | output | 2 | Drive enables, bit 0 lines 7:0, bit 1 lines 15:8 |
| ad_i | input | 16 | Address/data lines, sampled value |
| xfer_done_o | output | 1 | High during t4 of each transfer |
| rdata_o | output | 16 | Captured read data, valid with xfer_done_o |

## Verification
A phase sequencer stuck or mis-stepped shows at once in the strobe pattern. An extra or missing strobe clock, or a strobe still low in t4, appears within the same transfer as a wrong count between `ads_o` and `xfer_done_o`. A pointer or counter fault shows at the next address phase as a wrong address on `ad_o`, or at the end of the burst as a transfer too many or too few. A lost grant handling fault shows one clock after the interrupted t4 as a still-driven bus or a dropped request. A wrong lane enable shows in the first strobe clock of the affected transfer.

// File: rtl/bme_pkg.sv
package bme_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_REQ,
    PH_T1,
    PH_T2,
    PH_T3,
    PH_TW,
    PH_T4
  } phase_e;
endpackage

// File: rtl/bme_seq.sv
module bme_seq
  import bme_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_ok_i,
  input  logic   bgnt_i,
  input  logic   ready_i,
  input  logic   last_i,
  output phase_e phase_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start_ok_i) phase_d = PH_REQ;
      PH_REQ:  if (bgnt_i) phase_d = PH_T1;
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = PH_T3;
      PH_T3:   phase_d = ready_i ? PH_TW : PH_T4;
      PH_TW:   phase_d = ready_i ? PH_TW : PH_T4;
      PH_T4: begin
        // a cycle in flight always finishes; grant is checked only here
        if (last_i)       phase_d = PH_IDLE;
        else if (!bgnt_i) phase_d = PH_REQ;
        else              phase_d = PH_T1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/bme_ptr.sv
module bme_ptr #(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] addr_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          write_i,
  input  logic          byte_i,
  input  logic          adv_i,
  output logic [DW-1:0] addr_o,
  output logic          last_o,
  output logic          write_o,
  output logic          byte_o
);
  localparam logic [DW-1:0] WORD_STEP = DW'(DW / 8);
  localparam logic [DW-1:0] BYTE_STEP = DW'(1);

  logic [DW-1:0] addr_q;
  logic [CW-1:0] rem_q;
  logic          write_q, byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      rem_q   <= '0;
      write_q <= 1'b0;
      byte_q  <= 1'b0;
    end else if (load_i) begin
      addr_q  <= addr_i;
      rem_q   <= cnt_i;
      write_q <= write_i;
      byte_q  <= byte_i;
    end else if (adv_i) begin
      addr_q <= addr_q + (byte_q ? BYTE_STEP : WORD_STEP);
      rem_q  <= rem_q - CW'(1);
    end
  end

  assign addr_o  = addr_q;
  assign last_o  = (rem_q == CW'(1));
  assign write_o = write_q;
  assign byte_o  = byte_q;
endmodule

// File: rtl/bme_drv.sv
module bme_drv
  import bme_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        phase_i,
  input  logic [DW-1:0] addr_i,
  input  logic          write_i,
  input  logic          byte_i,
  input  logic          ready_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] ad_i,
  output logic          ads_o,
  output logic          mwr_n_o,
  output logic          mrd_n_o,
  output logic          strobe_oe_o,
  output logic [DW-1:0] ad_o,
  output logic [1:0]    ad_oe_o,
  output logic [DW-1:0] rdata_o
);
  localparam int HW = DW / 2;

  logic t1, strobe_ph, data_ph, own, cap;
  logic [DW-1:0] wdata_q, rdata_q;

  assign t1        = (phase_i == PH_T1);
  assign strobe_ph = (phase_i == PH_T2) || (phase_i == PH_T3) || (phase_i == PH_TW);
  assign data_ph   = strobe_ph || (phase_i == PH_T4);
  assign own       = t1 || data_ph;
  // strobe rises on the edge that leaves t3/tw with ready low
  assign cap       = ((phase_i == PH_T3) || (phase_i == PH_TW)) && !ready_i && !write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (t1) wdata_q <= wdata_i;
      if (cap) rdata_q <= byte_i ? {{(DW - HW){1'b0}}, ad_i[HW-1:0]} : ad_i;
    end
  end

  assign ads_o       = t1;
  assign strobe_oe_o = own;
  assign mwr_n_o     = !(strobe_ph && write_i);
  assign mrd_n_o     = !(strobe_ph && !write_i);
  assign rdata_o     = rdata_q;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HW-1:0] val;
    logic [HW-1:0] a_h, d_h;
    assign a_h = addr_i[h*HW +: HW];
    assign d_h = wdata_q[h*HW +: HW];
    if (h == 0) begin : g_lo
      assign ad_oe_o[h] = t1 || (data_ph && write_i);
      assign val        = t1 ? a_h : d_h;
    end else begin : g_hi
      // byte mode keeps the upper address byte on the bus
      assign ad_oe_o[h] = t1 || (data_ph && (write_i || byte_i));
      assign val        = (t1 || byte_i) ? a_h : d_h;
    end
    assign ad_o[h*HW +: HW] = ad_oe_o[h] ? val : '0;
  end
endmodule

// File: rtl/bm_cycle_engine.sv
module bm_cycle_engine
  import bme_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          write_i,
  input  logic          byte_mode_i,
  input  logic [DW-1:0] start_addr_i,
  input  logic [CW-1:0] xfer_cnt_i,
  input  logic [DW-1:0] wdata_i,
  output logic          breq_o,
  input  logic          bgnt_i,
  input  logic          ready_i,
  output logic          ads_o,
  output logic          mwr_n_o,
  output logic          mrd_n_o,
  output logic          strobe_oe_o,
  output logic [DW-1:0] ad_o,
  output logic [1:0]    ad_oe_o,
  input  logic [DW-1:0] ad_i,
  output logic          xfer_done_o,
  output logic [DW-1:0] rdata_o
);
  phase_e        phase;
  logic          start_ok, last, adv, write_q, byte_q;
  logic [DW-1:0] addr_q;

  assign start_ok = start_i && (phase == PH_IDLE) && (xfer_cnt_i != '0);
  assign adv      = (phase == PH_T4);

  bme_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_ok_i (start_ok),
    .bgnt_i     (bgnt_i),
    .ready_i    (ready_i),
    .last_i     (last),
    .phase_o    (phase)
  );

  bme_ptr #(.DW(DW), .CW(CW)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_ok),
    .addr_i  (start_addr_i),
    .cnt_i   (xfer_cnt_i),
    .write_i (write_i),
    .byte_i  (byte_mode_i),
    .adv_i   (adv),
    .addr_o  (addr_q),
    .last_o  (last),
    .write_o (write_q),
    .byte_o  (byte_q)
  );

  bme_drv #(.DW(DW)) u_drv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_i     (phase),
    .addr_i      (addr_q),
    .write_i     (write_q),
    .byte_i      (byte_q),
    .ready_i     (ready_i),
    .wdata_i     (wdata_i),
    .ad_i        (ad_i),
    .ads_o       (ads_o),
    .mwr_n_o     (mwr_n_o),
    .mrd_n_o     (mrd_n_o),
    .strobe_oe_o (strobe_oe_o),
    .ad_o        (ad_o),
    .ad_oe_o     (ad_oe_o),
    .rdata_o     (rdata_o)
  );

  assign breq_o      = (phase != PH_IDLE);
  assign xfer_done_o = (phase == PH_T4);
endmodule

// File: rtl/bme_checker.sv
module bme_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       breq_o,
  input logic       bgnt_i,
  input logic       ready_i,
  input logic       ads_o,
  input logic       mwr_n_o,
  input logic       mrd_n_o,
  input logic       strobe_oe_o,
  input logic [1:0] ad_oe_o,
  input logic       xfer_done_o
);
  logic stb;
  assign stb = strobe_oe_o && !(mwr_n_o && mrd_n_o);

  p_quiet_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !breq_o |-> (!strobe_oe_o && ad_oe_o == 2'b00 && !ads_o));

  p_own_needs_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_oe_o |-> breq_o);

  p_tenure_after_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_o && !$past(strobe_oe_o)) |-> $past(bgnt_i));

  p_addr_phase_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ads_o |-> (ad_oe_o == 2'b11 && mwr_n_o && mrd_n_o));

  p_strobe_follows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ads_o |=> stb);

  p_one_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_oe_o |-> (mwr_n_o || mrd_n_o));

  p_wait_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && ready_i) |=> stb);

  p_close_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> ($past(stb) && mwr_n_o && mrd_n_o && strobe_oe_o));

  p_release_after_close_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_oe_o) |-> $past(xfer_done_o));
endmodule

bind bm_cycle_engine bme_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .breq_o      (breq_o),
  .bgnt_i      (bgnt_i),
  .ready_i     (ready_i),
  .ads_o       (ads_o),
  .mwr_n_o     (mwr_n_o),
  .mrd_n_o     (mrd_n_o),
  .strobe_oe_o (strobe_oe_o),
  .ad_oe_o     (ad_oe_o),
  .xfer_done_o (xfer_done_o)
);

// File: tb/bm_cycle_engine_bench.sv
module bm_cycle_engine_bench;
  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0, write_i = 1'b0, byte_mode_i = 1'b0;
  logic [DW-1:0] start_addr_i = '0;
  logic [CW-1:0] xfer_cnt_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          breq_o;
  logic          bgnt_i = 1'b0;
  logic          ready_i = 1'b0;
  logic          ads_o, mwr_n_o, mrd_n_o, strobe_oe_o, xfer_done_o;
  logic [DW-1:0] ad_o, rdata_o;
  logic [1:0]    ad_oe_o;
  logic [DW-1:0] ad_i = '0;

  always #4 clk_i = ~clk_i;

  bm_cycle_engine #(.DW(DW), .CW(CW)) u_bm_cycle_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .write_i(write_i),
    .byte_mode_i(byte_mode_i), .start_addr_i(start_addr_i), .xfer_cnt_i(xfer_cnt_i),
    .wdata_i(wdata_i), .breq_o(breq_o), .bgnt_i(bgnt_i), .ready_i(ready_i),
    .ads_o(ads_o), .mwr_n_o(mwr_n_o), .mrd_n_o(mrd_n_o), .strobe_oe_o(strobe_oe_o),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ad_i(ad_i), .xfer_done_o(xfer_done_o),
    .rdata_o(rdata_o)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic        wr;
    logic        byt;
    logic [3:0]  w;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   n_chk = 0, n_bad = 0, xfers = 0, k = 0, base_x = 0;
  logic gnt_d = 1'b0, drop_gnt = 1'b0, finished = 1'b0;

  function automatic logic [15:0] wpat(logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] rpat(logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'hC3E1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    #1;
  endtask

  // grant model and scoreboard monitor, at the falling edge
  always @(negedge clk_i) begin
    logic [15:0] ew, er;
    if (rst_ni) begin
      gnt_d  <= breq_o;
      bgnt_i <= breq_o && gnt_d && !drop_gnt;
      if (ads_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R12", "t1 with nothing expected", 32'(ad_o), 32'hFFFF_FFFF);
        end else begin
          cur = q.pop_front();
          chk(ad_o == cur.addr, "R9", "t1 address", 32'(ad_o), 32'(cur.addr));
          chk(ad_oe_o == 2'b11 && mwr_n_o && mrd_n_o, "R3", "t1 enables/strobes",
              {29'b0, ad_oe_o, mwr_n_o & mrd_n_o}, 32'h7);
        end
        k = 0;
        wdata_i <= wpat(cur.addr);
        ad_i    <= rpat(cur.addr);
        ready_i <= 1'b0;
      end else if (strobe_oe_o && !(mwr_n_o && mrd_n_o)) begin
        k++;
        ready_i <= (int'(cur.w) > ((k > 2) ? (k - 2) : 0));
        ew = wpat(cur.addr);
        if (cur.wr) begin
          chk(!mwr_n_o && mrd_n_o, "R6", "write strobe", {30'b0, mwr_n_o, mrd_n_o}, 32'h1);
          if (cur.byt) begin
            ew = {cur.addr[15:8], ew[7:0]};
            chk(ad_oe_o == 2'b11 && ad_o == ew, "R8", "byte write lanes",
                {14'b0, ad_oe_o, ad_o}, {14'b0, 2'b11, ew});
          end else begin
            chk(ad_oe_o == 2'b11 && ad_o == ew, "R6", "word write data",
                {14'b0, ad_oe_o, ad_o}, {14'b0, 2'b11, ew});
          end
        end else begin
          chk(mwr_n_o && !mrd_n_o, "R7", "read strobe", {30'b0, mwr_n_o, mrd_n_o}, 32'h2);
          if (cur.byt)
            chk(ad_oe_o == 2'b10 && ad_o[15:8] == cur.addr[15:8], "R8", "byte read lanes",
                {14'b0, ad_oe_o, ad_o}, {14'b0, 2'b10, cur.addr[15:8], 8'h00});
          else
            chk(ad_oe_o == 2'b00, "R7", "word read release", 32'(ad_oe_o), 32'h0);
        end
      end else if (xfer_done_o) begin
        chk(k == 2 + int'(cur.w), (cur.w == 0) ? "R4" : "R5", "strobe clocks",
            32'(k), 32'(2 + int'(cur.w)));
        chk(mwr_n_o && mrd_n_o && strobe_oe_o, "R4", "t4 strobes high",
            {30'b0, mwr_n_o & mrd_n_o, strobe_oe_o}, 32'h3);
        ew = wpat(cur.addr);
        er = rpat(cur.addr);
        if (cur.wr) begin
          if (cur.byt) ew = {cur.addr[15:8], ew[7:0]};
          chk(ad_oe_o == 2'b11 && ad_o == ew, "R6", "t4 write data held",
              {14'b0, ad_oe_o, ad_o}, {14'b0, 2'b11, ew});
        end else begin
          if (cur.byt) er = {8'h00, er[7:0]};
          chk(rdata_o == er, "R7", "read data", 32'(rdata_o), 32'(er));
        end
        xfers++;
        ready_i <= 1'b0;
      end
    end
  end

  task automatic run_burst(input logic wr, input logic byt, input logic [15:0] addr,
                           input int cnt, input int w);
    int b;
    int guard;
    exp_t e;
    for (int i = 0; i < cnt; i++) begin
      e.addr = addr + 16'(i * (byt ? 1 : 2));
      e.wr   = wr;
      e.byt  = byt;
      e.w    = 4'(w);
      q.push_back(e);
    end
    b = xfers;
    start_i      = 1'b1;
    write_i      = wr;
    byte_mode_i  = byt;
    start_addr_i = addr;
    xfer_cnt_i   = CW'(cnt);
    tick();
    start_i = 1'b0;
    chk(breq_o, "R1", "request after start", 32'(breq_o), 32'h1);
    guard = 0;
    while (breq_o && guard < 5000) begin
      tick();
      guard++;
    end
    chk(xfers - b == cnt, "R10", "transfer count", 32'(xfers - b), 32'(cnt));
    chk(xfers - b == cnt, "R1", "request dropped after last t4", 32'(xfers - b), 32'(cnt));
    chk(q.size() == 0, "R10", "expected queue drained", 32'(q.size()), 32'h0);
    chk(!strobe_oe_o && ad_oe_o == 2'b00, "R2", "bus released after burst",
        {29'b0, strobe_oe_o, ad_oe_o}, 32'h0);
    tick();
  endtask

  initial begin
    repeat (3) tick();
    chk(!breq_o && !strobe_oe_o && ad_oe_o == 2'b00 && !ads_o && !xfer_done_o, "R2",
        "reset state", {27'b0, breq_o, strobe_oe_o, ad_oe_o, ads_o}, 32'h0);
    rst_ni = 1'b1;
    repeat (2) tick();
    chk(!breq_o && !strobe_oe_o && ad_oe_o == 2'b00, "R2", "idle after reset",
        {29'b0, breq_o, strobe_oe_o, ad_oe_o[0]}, 32'h0);

    run_burst(1'b1, 1'b0, 16'h1000, 3, 0);
    run_burst(1'b0, 1'b0, 16'h2002, 3, 0);
    run_burst(1'b1, 1'b1, 16'h30FE, 4, 1);
    run_burst(1'b0, 1'b1, 16'hFFFE, 3, 2);   // R9 wrap
    run_burst(1'b1, 1'b0, 16'hFFFC, 3, 3);   // R9 word wrap, R5 long wait

    // R10: zero count ignored
    start_i = 1'b1; xfer_cnt_i = '0; start_addr_i = 16'h7777;
    tick();
    start_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(!breq_o && !ads_o, "R10", "zero count start", 32'(breq_o), 32'h0);
      tick();
    end

    // R11: grant withdrawn mid-burst
    base_x = xfers;
    fork
      run_burst(1'b0, 1'b0, 16'h4000, 4, 0);
      begin
        wait (xfers == base_x + 1);
        tick();
        while (!(strobe_oe_o && !(mwr_n_o && mrd_n_o))) tick();
        drop_gnt = 1'b1;
        while (!xfer_done_o) tick();
        tick();
        chk(!strobe_oe_o && ad_oe_o == 2'b00 && breq_o, "R11", "released, still requesting",
            {29'b0, strobe_oe_o, ad_oe_o[0], breq_o}, 32'h1);
        chk(xfers == base_x + 2, "R11", "interrupted cycle completed",
            32'(xfers - base_x), 32'h2);
        for (int i = 0; i < 4; i++) begin
          tick();
          chk(!ads_o && !strobe_oe_o, "R11", "no t1 without grant", 32'(ads_o), 32'h0);
        end
        drop_gnt = 1'b0;
      end
    join

    // R12: start while busy ignored
    base_x = xfers;
    fork
      run_burst(1'b1, 1'b0, 16'h5000, 3, 1);
      begin
        wait (xfers == base_x + 1);
        tick();
        start_i = 1'b1; start_addr_i = 16'hABCD; xfer_cnt_i = 8'd5;
        tick();
        start_i = 1'b0;
      end
    join
    repeat (4) tick();
    chk(xfers - base_x == 3 && !breq_o, "R12", "busy start ignored",
        32'(xfers - base_x), 32'h3);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule